// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central dispatch controller of an in-order-issue, out-of-order-execute pipeline with several functional units. It accepts one decoded instruction at a time: a unit class, a destination register and two source registers. It places the instruction on a free unit of that class. It then tells each unit when it may read its operands from the register file and when it may write its result back. The units themselves are outside the block. Each unit reports that execution has finished with a single-cycle done pulse.

The control holds a per-unit table and a per-register pending-writer table. Each pipeline step has its own hazard check:

- **Issue** waits while no unit of the requested class is free, or while some unit still has to write the requested destination.
- **Operand read** waits until both sources are free of pending writers.
- **Write-back** waits while an older instruction still has to read the register being overwritten.

There is no bypass path, so results reach consumers only through the register file.

The default configuration has five units:

| Class | Function | Unit index |
|-------|----------|------------|
| 0 | integer | 0 |
| 1 | multiply | 1 and 2 |
| 2 | add | 3 |
| 3 | divide | 4 |

Top module: `scb_ctrl`

## Requirements
- R1: After reset every unit is idle. No operand-read or write-back grant is asserted. A valid request with any class and destination sees `in_ready` high.
- R2: A request is accepted on a cycle where `in_valid` and `in_ready` are both high, and at most one request is accepted per cycle. It goes to the lowest-indexed idle unit of its class: class 0 to unit 0, class 1 to unit 1 then unit 2, class 2 to unit 3, class 3 to unit 4. `iss_unit` reports that index in the same cycle.
- R3: `in_ready` is low while every unit of the requested class is busy (structural hazard).
- R4: `in_ready` is low while any active instruction still has to write the requested destination (WAW hazard).
- R5: A unit's `rd_grant` rises only when neither source has a pending writer. A source whose producer is granted write-back in cycle N can first be read in cycle N+1, with no bypass path. The grant lasts one cycle.
- R6: An instruction stalled on a source does not block later, independent instructions from reading their operands first.
- R7: A unit's `wb_grant` is withheld while an older instruction that names its destination as a source has not yet read it (WAR). The grant comes in the cycle after that read.
- R8: Completion is out of order. With no hazards, a unit is granted write-back exactly L+1 cycles after its `rd_grant` cycle, where L is the number of cycles from the start of execution to its done pulse.
- R9: Every operand read returns the value written by the latest earlier writer in program order. After draining, each register holds the result of its last writer in program order.
- R10: A done pulse to a unit that is not executing has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Instruction can be accepted this cycle |
| in_cls | input | CW | Unit class of the instruction |
| in_dst | input | RW | Destination register |
| in_src1 | input | RW | First source register |
| in_src2 | input | RW | Second source register |
| iss_unit | output | UW | Unit chosen for the instruction offered now |
| rd_grant | output | NUM_FU | Per-unit operand-read and start permission |
| ex_done | input | NUM_FU | Per-unit execution-finished pulse |
| wb_grant | output | NUM_FU | Per-unit write-back permission |

## Verification
The bench builds the default configuration of five units and sixteen registers. Its unit model uses latencies of 1, 6, 6, 2 and 10 cycles. The long divide latency against the short add and integer latencies makes structural, WAW, RAW and WAR stalls, and out-of-order completion, occur on hand-written sequences with exactly predictable cycles. A further pseudo-random program draws its operands from only six registers, so the hazards overlap. Each operand read and each final register is compared against a program-order version model.

// File: rtl/scb_pkg.sv
`timescale 1ns/1ps
package scb_pkg;
    // life cycle of one functional-unit entry
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_EXEC  = 2'd2,
        ST_WRITE = 2'd3
    } fu_st_e;
endpackage

// File: rtl/scb_issue_sel.sv
`timescale 1ns/1ps
// Picks the lowest idle unit of the requested class and applies the
// structural and output-dependence checks of the issue step.
module scb_issue_sel #(
    parameter int NUM_FU = 5,
    parameter int NUM_REGS = 16,
    parameter int CW = 2,
    parameter logic [NUM_FU*CW-1:0] FU_CLASS = '0,
    localparam int RW = $clog2(NUM_REGS),
    localparam int UW = (NUM_FU > 1) ? $clog2(NUM_FU) : 1
) (
    input  logic [NUM_FU-1:0]   idle,
    input  logic [NUM_REGS-1:0] pend,
    input  logic [CW-1:0]       cls,
    input  logic [RW-1:0]       dst,
    output logic                can_issue,
    output logic [UW-1:0]       sel
);
    logic [NUM_FU-1:0] match;

    for (genvar u = 0; u < NUM_FU; u++) begin : g_match
        assign match[u] = idle[u] && (FU_CLASS[u*CW +: CW] == cls);
    end

    always_comb begin
        sel = '0;
        for (int u = NUM_FU - 1; u >= 0; u--) begin
            if (match[u]) sel = UW'(u);
        end
    end

    assign can_issue = (|match) && !pend[dst];
endmodule

// File: rtl/scb_war_chk.sv
`timescale 1ns/1ps
// Write-back permission: a finished unit may write only when no entry
// still holds an unread source naming its destination.
module scb_war_chk #(
    parameter int NUM_FU = 5,
    parameter int NUM_REGS = 16,
    localparam int RW = $clog2(NUM_REGS)
) (
    input  logic [NUM_FU-1:0]         done_q,
    input  logic [NUM_FU-1:0]         read_q,
    input  logic [NUM_FU-1:0][RW-1:0] fi,
    input  logic [NUM_FU-1:0][RW-1:0] fj,
    input  logic [NUM_FU-1:0][RW-1:0] fk,
    input  logic [NUM_FU-1:0]         rj,
    input  logic [NUM_FU-1:0]         rk,
    output logic [NUM_FU-1:0]         wb_ok
);
    for (genvar w = 0; w < NUM_FU; w++) begin : g_wr
        logic [NUM_FU-1:0] block;
        for (genvar f = 0; f < NUM_FU; f++) begin : g_rd
            assign block[f] = read_q[f] &&
                              ((rj[f] && fj[f] == fi[w]) || (rk[f] && fk[f] == fi[w]));
        end
        assign wb_ok[w] = done_q[w] && !(|block);
    end
endmodule

// File: rtl/scb_ctrl.sv
`timescale 1ns/1ps
module scb_ctrl #(
    parameter int NUM_FU = 5,
    parameter int NUM_REGS = 16,
    parameter int CW = 2,
    // class of each unit, unit 0 in the low bits: int, mul, mul, add, div
    parameter logic [NUM_FU*CW-1:0] FU_CLASS = {2'd3, 2'd2, 2'd1, 2'd1, 2'd0},
    localparam int RW = $clog2(NUM_REGS),
    localparam int UW = (NUM_FU > 1) ? $clog2(NUM_FU) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CW-1:0]     in_cls,
    input  logic [RW-1:0]     in_dst,
    input  logic [RW-1:0]     in_src1,
    input  logic [RW-1:0]     in_src2,
    output logic [UW-1:0]     iss_unit,
    output logic [NUM_FU-1:0] rd_grant,
    input  logic [NUM_FU-1:0] ex_done,
    output logic [NUM_FU-1:0] wb_grant
);
    import scb_pkg::*;

    typedef struct packed {
        fu_st_e        st;
        logic [CW-1:0] op;
        logic [RW-1:0] fi;
        logic [RW-1:0] fj;
        logic [RW-1:0] fk;
        logic [UW-1:0] qj;
        logic [UW-1:0] qk;
        logic          qjv;
        logic          qkv;
        logic          rj;
        logic          rk;
    } fu_ent_t;

    typedef struct packed {
        fu_ent_t [NUM_FU-1:0]           fu;
        logic    [NUM_REGS-1:0]         res_v;
        logic    [NUM_REGS-1:0][UW-1:0] res_u;
    } sb_t;

    sb_t sb_d, sb_q;

    // flattened views shared by the hazard modules and the checker
    logic [NUM_FU-1:0]         idle_q, read_q, done_q, qpend_q, rj_q, rk_q;
    logic [NUM_FU-1:0][RW-1:0] fi_q, fj_q, fk_q;
    logic [NUM_REGS-1:0]       res_v_q;
    logic                      fire;

    for (genvar u = 0; u < NUM_FU; u++) begin : g_view
        assign idle_q[u]  = sb_q.fu[u].st == ST_IDLE;
        assign read_q[u]  = sb_q.fu[u].st == ST_READ;
        assign done_q[u]  = sb_q.fu[u].st == ST_WRITE;
        assign qpend_q[u] = sb_q.fu[u].qjv || sb_q.fu[u].qkv;
        assign rj_q[u]    = sb_q.fu[u].rj;
        assign rk_q[u]    = sb_q.fu[u].rk;
        assign fi_q[u]    = sb_q.fu[u].fi;
        assign fj_q[u]    = sb_q.fu[u].fj;
        assign fk_q[u]    = sb_q.fu[u].fk;
    end
    assign res_v_q = sb_q.res_v;

    scb_issue_sel #(
        .NUM_FU(NUM_FU), .NUM_REGS(NUM_REGS), .CW(CW), .FU_CLASS(FU_CLASS)
    ) issue_i (
        .idle(idle_q), .pend(res_v_q), .cls(in_cls), .dst(in_dst),
        .can_issue(in_ready), .sel(iss_unit)
    );

    scb_war_chk #(
        .NUM_FU(NUM_FU), .NUM_REGS(NUM_REGS)
    ) war_i (
        .done_q(done_q), .read_q(read_q), .fi(fi_q), .fj(fj_q), .fk(fk_q),
        .rj(rj_q), .rk(rk_q), .wb_ok(wb_grant)
    );

    assign fire = in_valid && in_ready;

    always_comb begin
        sb_d = sb_q;
        for (int u = 0; u < NUM_FU; u++) begin
            rd_grant[u] = (sb_q.fu[u].st == ST_READ) && sb_q.fu[u].rj && sb_q.fu[u].rk;
        end
        for (int u = 0; u < NUM_FU; u++) begin
            if (rd_grant[u]) begin
                sb_d.fu[u].st = ST_EXEC;
                sb_d.fu[u].rj = 1'b0;
                sb_d.fu[u].rk = 1'b0;
            end else if (sb_q.fu[u].st == ST_EXEC && ex_done[u]) begin
                sb_d.fu[u].st = ST_WRITE;
            end
            if (wb_grant[u]) begin
                sb_d.fu[u].st = ST_IDLE;
                sb_d.res_v[sb_q.fu[u].fi] = 1'b0;
                for (int f = 0; f < NUM_FU; f++) begin
                    if (sb_q.fu[f].qjv && sb_q.fu[f].qj == UW'(u)) begin
                        sb_d.fu[f].qjv = 1'b0;
                        sb_d.fu[f].rj  = 1'b1;
                    end
                    if (sb_q.fu[f].qkv && sb_q.fu[f].qk == UW'(u)) begin
                        sb_d.fu[f].qkv = 1'b0;
                        sb_d.fu[f].rk  = 1'b1;
                    end
                end
            end
        end
        if (fire) begin
            sb_d.fu[iss_unit].st  = ST_READ;
            sb_d.fu[iss_unit].op  = in_cls;
            sb_d.fu[iss_unit].fi  = in_dst;
            sb_d.fu[iss_unit].fj  = in_src1;
            sb_d.fu[iss_unit].fk  = in_src2;
            sb_d.fu[iss_unit].qj  = sb_q.res_u[in_src1];
            sb_d.fu[iss_unit].qk  = sb_q.res_u[in_src2];
            // a producer writing back this cycle counts as already done
            sb_d.fu[iss_unit].qjv = sb_q.res_v[in_src1] && !wb_grant[sb_q.res_u[in_src1]];
            sb_d.fu[iss_unit].qkv = sb_q.res_v[in_src2] && !wb_grant[sb_q.res_u[in_src2]];
            sb_d.fu[iss_unit].rj  = !sb_d.fu[iss_unit].qjv;
            sb_d.fu[iss_unit].rk  = !sb_d.fu[iss_unit].qkv;
            sb_d.res_v[in_dst]    = 1'b1;
            sb_d.res_u[in_dst]    = iss_unit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sb_q <= '0;
        else        sb_q <= sb_d;
    end
endmodule

// File: rtl/scb_ctrl_chk.sv
`timescale 1ns/1ps
module scb_ctrl_chk #(
    parameter int NUM_FU = 5,
    parameter int NUM_REGS = 16,
    localparam int RW = $clog2(NUM_REGS),
    localparam int UW = (NUM_FU > 1) ? $clog2(NUM_FU) : 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic                      in_ready,
    input logic [RW-1:0]             in_dst,
    input logic [UW-1:0]             iss_unit,
    input logic [NUM_FU-1:0]         rd_grant,
    input logic [NUM_FU-1:0]         wb_grant,
    input logic [NUM_FU-1:0]         idle_q,
    input logic [NUM_FU-1:0]         qpend_q,
    input logic [NUM_REGS-1:0]       res_v_q,
    input logic [NUM_FU-1:0][RW-1:0] fi_q
);
    // R3
    issue_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |-> idle_q[iss_unit]);

    // R4
    issue_no_waw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |-> !res_v_q[in_dst]);

    for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
        // R5
        read_no_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_grant[u] |-> !qpend_q[u]);

        // R5
        read_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_grant[u] |=> !rd_grant[u]);

        // R4
        wb_owns_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wb_grant[u] |-> res_v_q[fi_q[u]]);

        // R8
        wb_frees_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wb_grant[u] |=> idle_q[u] && !res_v_q[$past(fi_q[u])]);
    end
endmodule

bind scb_ctrl scb_ctrl_chk #(.NUM_FU(NUM_FU), .NUM_REGS(NUM_REGS)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dst(in_dst), .iss_unit(iss_unit), .rd_grant(rd_grant),
    .wb_grant(wb_grant), .idle_q(idle_q), .qpend_q(qpend_q),
    .res_v_q(res_v_q), .fi_q(fi_q)
);

// File: tb/scb_ctrl_tb_top.sv
`timescale 1ns/1ps
module scb_ctrl_tb_top;
    localparam int NFU = 5;
    localparam int NRG = 16;
    localparam int MAXID = 128;
    localparam int LAT [NFU] = '{1, 6, 6, 2, 10};

    typedef struct {
        int id;
        int v1;
        int v2;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [1:0] in_cls = '0;
    logic [3:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic [2:0] iss_unit;
    logic [NFU-1:0] rd_grant, wb_grant, ex_done;
    logic [NFU-1:0] model_done = '0;
    logic [NFU-1:0] stray = '0;

    assign ex_done = model_done | stray;

    always #4 clk = ~clk;

    scb_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_cls(in_cls), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .iss_unit(iss_unit), .rd_grant(rd_grant), .ex_done(ex_done),
        .wb_grant(wb_grant)
    );

    int total = 0, bad = 0, cyc = 0, nid = 0;
    bit finished = 1'b0;
    int unit_id [NFU];
    int cnt [NFU];
    int id_dst [MAXID], id_s1 [MAXID], id_s2 [MAXID];
    int rd_cyc [MAXID], wb_cyc [MAXID];
    int reg_ver [NRG], prog_ver [NRG];
    exp_t exp_q [$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops expected reads, tracks register versions, models units
    always @(negedge clk) begin
        if (rst_n) begin
            for (int u = 0; u < NFU; u++) begin
                if (rd_grant[u]) begin
                    int id;
                    int hit;
                    id = unit_id[u];
                    rd_cyc[id] = cyc;
                    hit = -1;
                    for (int i = 0; i < exp_q.size(); i++) if (exp_q[i].id == id) hit = i;
                    if (hit < 0) chk(1'b0, "R9", "unexpected read id", id, 0);
                    else begin
                        chk(reg_ver[id_s1[id]] == exp_q[hit].v1, "R9", "src1 version",
                            reg_ver[id_s1[id]], exp_q[hit].v1);
                        chk(reg_ver[id_s2[id]] == exp_q[hit].v2, "R9", "src2 version",
                            reg_ver[id_s2[id]], exp_q[hit].v2);
                        exp_q.delete(hit);
                    end
                end
            end
            for (int u = 0; u < NFU; u++) begin
                if (wb_grant[u]) begin
                    wb_cyc[unit_id[u]] = cyc;
                    reg_ver[id_dst[unit_id[u]]] = unit_id[u];
                end
            end
            for (int u = 0; u < NFU; u++) begin
                model_done[u] = 1'b0;
                if (rd_grant[u]) cnt[u] = LAT[u];
                else if (cnt[u] > 0) begin
                    cnt[u] = cnt[u] - 1;
                    if (cnt[u] == 0) model_done[u] = 1'b1;
                end
            end
        end
    end

    task automatic issue(input int cls, input int dst, input int s1, input int s2,
                         input int exp_u);
        @(negedge clk);
        in_valid = 1'b1; in_cls = 2'(cls); in_dst = 4'(dst);
        in_src1 = 4'(s1); in_src2 = 4'(s2);
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        nid++;
        unit_id[iss_unit] = nid;
        id_dst[nid] = dst; id_s1[nid] = s1; id_s2[nid] = s2;
        exp_q.push_back('{nid, prog_ver[s1], prog_ver[s2]});
        prog_ver[dst] = nid;
        if (exp_u >= 0) chk(int'(iss_unit) == exp_u, "R2", "unit chosen", iss_unit, exp_u);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic probe(input int cls, input int dst, output bit rdy);
        @(negedge clk);
        in_valid = 1'b1; in_cls = 2'(cls); in_dst = 4'(dst);
        in_src1 = 4'd0; in_src2 = 4'd0;
        #1;
        rdy = in_ready;
        in_valid = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", cyc, 0);
        summary();
    end

    initial begin
        bit rdy;
        int seed;
        for (int r = 0; r < NRG; r++) begin reg_ver[r] = 0; prog_ver[r] = 0; end
        for (int u = 0; u < NFU; u++) begin cnt[u] = 0; unit_id[u] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk(rd_grant == '0, "R1", "rd_grant after reset", int'(rd_grant), 0);
        chk(wb_grant == '0, "R1", "wb_grant after reset", int'(wb_grant), 0);
        probe(3, 9, rdy);
        chk(rdy, "R1", "ready after reset", rdy, 1);

        // R2 and R3: both multiply units taken, third multiply stalls
        issue(1, 1, 2, 3, 1);
        issue(1, 4, 2, 3, 2);
        probe(1, 5, rdy);
        chk(!rdy, "R3", "mul stall when both busy", rdy, 0);

        // R4: divide on r6 blocks an add to r6
        issue(3, 6, 2, 3, 4);
        probe(2, 6, rdy);
        chk(!rdy, "R4", "WAW stall on r6", rdy, 0);

        // R5, R6, R7: add waits on r6; int writes r8 that the add still reads
        issue(2, 7, 6, 8, 3);
        issue(0, 8, 9, 9, 0);
        repeat (40) @(negedge clk);
        chk(rd_cyc[4] == wb_cyc[3] + 1, "R5", "read one cycle after producer wb",
            rd_cyc[4], wb_cyc[3] + 1);
        chk(rd_cyc[5] < rd_cyc[4], "R6", "younger read overtakes stalled one",
            rd_cyc[5], rd_cyc[4]);
        chk(wb_cyc[5] == rd_cyc[4] + 1, "R7", "WAR-held wb cycle",
            wb_cyc[5], rd_cyc[4] + 1);

        // R8: long divide then short add, add finishes first
        issue(3, 11, 2, 3, 4);
        issue(2, 12, 2, 3, 3);
        repeat (30) @(negedge clk);
        chk(wb_cyc[7] < wb_cyc[6], "R8", "add completes before divide", wb_cyc[7], wb_cyc[6]);
        chk(wb_cyc[7] - rd_cyc[7] == LAT[3] + 1, "R8", "add read-to-wb distance",
            wb_cyc[7] - rd_cyc[7], LAT[3] + 1);

        // R10: stray done pulse on the idle divide unit
        @(negedge clk); stray[4] = 1'b1;
        @(negedge clk); stray[4] = 1'b0;
        chk(wb_grant == '0, "R10", "no wb after stray done", int'(wb_grant), 0);
        issue(3, 13, 1, 1, 4);
        repeat (20) @(negedge clk);
        chk(wb_cyc[8] - rd_cyc[8] == LAT[4] + 1, "R10", "divide latency after stray",
            wb_cyc[8] - rd_cyc[8], LAT[4] + 1);

        // R9: pseudo-random program over a small register pool
        seed = 32'h1234;
        for (int n = 0; n < 40; n++) begin
            seed = seed * 1103515245 + 12345;
            issue((seed >>> 16) & 3, 1 + ((seed >>> 8) & 32'hff) % 6,
                  1 + ((seed >>> 4) & 32'hff) % 6, 1 + ((seed >>> 20) & 32'hff) % 6, -1);
        end
        repeat (60) @(negedge clk);
        chk(exp_q.size() == 0, "R9", "all reads performed", exp_q.size(), 0);
        for (int r = 0; r < NRG; r++) begin
            chk(reg_ver[r] == prog_ver[r], "R9", $sformatf("final version r%0d", r),
                reg_ver[r], prog_ver[r]);
        end
        probe(1, 1, rdy);
        chk(rdy, "R1", "ready after drain", rdy, 1);
        summary();
    end
endmodule